// File: doc/BRIEF.md
# Fault Event Log Ring Writer

This block records fault and error events in a circular log kept in system memory, where software reads them back at its own pace. Several event sources present fixed-format records. The block picks one source at a time and formats the record into a 16-byte entry. It writes that entry at the log base plus the current tail offset, then moves the tail forward. Software reads entries from the head offset and writes a new head value to hand the slots back.

Software programs the log through a small register port. That port holds the log base, a control word (logging enable, interrupt enable, ring size exponent), the head and tail offsets, and a status word. When the ring has no free slot, an incoming event is still acknowledged, but it is discarded and a sticky overflow flag records the loss. An optional one-cycle interrupt pulse follows every entry that reaches memory.

Top module: `evlog_ring_producer`

## Requirements
- R1: After reset the control word, head, tail and status all read zero, memWrValid and evtIrq are low, and no source is acknowledged.
- R2: The register map uses 16-bit offsets. 0x0010 is the base; only bits 63:12 are kept and the low 12 bits read zero. 0x0018 is control: bit0 logging enable, bit1 interrupt enable, bits 11:8 size exponent E, giving 2^E entries, with E=0 treated as 1. 0x2010 is head and 0x2018 is tail; both are byte offsets where only bits [MAX_EXP+3:4] are kept. 0x2020 is status, with bit0 the overflow flag. Any other offset reads zero.
- R3: Each accepted event that is not dropped produces exactly one 128-bit memory write at the address base + tail.
- R4: Entry layout: bits 3:0 event code, 31:16 requester ID, 47:32 domain ID, 127:64 faulting address, all other bits zero. Codes 1..8 are: bad device entry, page fault, device table error, page table error, bad request, command error, illegal command, invalidation timeout.
- R5: When a memory write completes, tail advances by 16 bytes, modulo 16 * 2^E, so it wraps to zero after the last slot.
- R6: When several sources are valid in the same cycle, the lowest-index source is acknowledged first. Only one source is acknowledged per cycle.
- R7: While logging is disabled, no source is acknowledged and nothing is written.
- R8: With the interrupt enabled, evtIrq pulses for one cycle, in the cycle after each completed memory write. With it disabled, evtIrq never pulses.
- R9: If (tail + 16) mod ring size equals head, an event is acknowledged but discarded. No write occurs, tail is unchanged and the overflow flag is set.
- R10: A software write to head that opens a free slot lets the next event be written.
- R11: The overflow flag stays set until software writes status with bit0 = 1.
- R12: While memWrReady is low, memWrValid stays high with stable address and data, and tail does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | NUM_SRC | Event present, one bit per source |
| srcCode | input | NUM_SRC x 4 | Event code per source |
| srcRid | input | NUM_SRC x 16 | Requester ID per source |
| srcDom | input | NUM_SRC x 16 | Domain ID per source |
| srcAddr | input | NUM_SRC x 64 | Faulting address per source |
| srcReady | output | NUM_SRC | Event taken this cycle (written or dropped) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 16 | Register offset for read and write |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data for regAddr |
| memWrValid | output | 1 | Entry write request |
| memWrReady | input | 1 | Memory accepts the write |
| memWrAddr | output | 64 | Byte address of the entry |
| memWrData | output | 128 | Formatted entry |
| evtIrq | output | 1 | One-cycle pulse after each written entry |

## Verification
The hardest state to reach is a ring that is exactly full, followed by a head update that frees one slot. Reaching it takes a small ring, a known head, and precisely one event fewer than the ring size. The stimulus shrinks the ring to four entries and resets head and tail to zero. It sends three events to fill the ring and then a fourth, which must be dropped and must set the sticky flag. Software then moves head forward by one slot, and one more event must land in the last slot and wrap tail back to zero. Simultaneous requests and a stalled memory port are produced by forking two source drivers on the same edge and by holding memWrReady low.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

  localparam int ENTRY_BYTES = 16;

  localparam logic [15:0] OFS_BASE = 16'h0010;
  localparam logic [15:0] OFS_CTRL = 16'h0018;
  localparam logic [15:0] OFS_HEAD = 16'h2010;
  localparam logic [15:0] OFS_TAIL = 16'h2018;
  localparam logic [15:0] OFS_STAT = 16'h2020;

  typedef enum logic [3:0] {
    EV_NONE          = 4'd0,
    EV_BAD_DEV_ENTRY = 4'd1,
    EV_PAGE_FAULT    = 4'd2,
    EV_DEVTAB_ERR    = 4'd3,
    EV_PGTAB_ERR     = 4'd4,
    EV_BAD_REQUEST   = 4'd5,
    EV_CMD_ERR       = 4'd6,
    EV_BAD_CMD       = 4'd7,
    EV_INVAL_TIMEOUT = 4'd8
  } evCode_e;

  typedef struct packed {
    logic [3:0]  code;
    logic [15:0] rid;
    logic [15:0] dom;
    logic [63:0] addr;
  } evRec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch winning record, entry write follows
    logic drop;      // ring full, discard and flag
    logic advance;   // write completed, move tail
  } ctlStrobe_t;

  function automatic logic [127:0] packEntry(evRec_t r);
    return {r.addr, 16'h0, r.dom, r.rid, 12'h0, r.code};
  endfunction

endpackage

// File: rtl/evlog_arb.sv
module evlog_arb #(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] reqVec,
  output logic [NUM_SRC-1:0] gntVec,
  output logic [IDX_W-1:0]   gntIdx,
  output logic               anyReq
);

  logic [NUM_SRC:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    assign gntVec[i]    = reqVec[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | reqVec[i];
  end

  assign anyReq = blocked[NUM_SRC];

  always_comb begin
    gntIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) gntIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
  import evlog_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic               logEn,
  input  logic               logFull,
  input  logic               memWrReady,
  output logic [NUM_SRC-1:0] srcReady,
  output logic [IDX_W-1:0]   winIdx,
  output ctlStrobe_t         strobe,
  output logic               memWrValid
);

  typedef enum logic {ST_IDLE, ST_WRITE} state_e;
  state_e state, stateNext;

  logic [NUM_SRC-1:0] gntVec;
  logic               anyReq;
  logic               takeEvt;

  evlog_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .reqVec (srcValid),
    .gntVec (gntVec),
    .gntIdx (winIdx),
    .anyReq (anyReq)
  );

  assign takeEvt = (state == ST_IDLE) && logEn && anyReq;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    srcReady       = '0;
    memWrValid     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (takeEvt) begin
          srcReady = gntVec;
          if (logFull) begin
            strobe.drop = 1'b1;
          end else begin
            strobe.capture = 1'b1;
            stateNext      = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        memWrValid = 1'b1;
        if (memWrReady) begin
          strobe.advance = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R6: at most one acknowledge per cycle
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcReady));

  // R6: no lower-index source may be waiting when one is acknowledged
  p_low_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srcReady != '0) |-> (((srcReady - 1'b1) & srcValid) == '0));

  // R7: disabled logging takes nothing
  p_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !logEn |-> (srcReady == '0));

  // R9: a dropped event is never followed by a write
  p_drop_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drop |=> !memWrValid);

  // R12: write request held under back-pressure
  p_hold_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady) |=> memWrValid);

endmodule

// File: rtl/evlog_dp.sv
module evlog_dp
  import evlog_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int MAX_EXP = 15,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int SLOT_W = MAX_EXP,
  localparam int PTR_W  = MAX_EXP + 4,
  localparam int EXP_W  = $clog2(MAX_EXP + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_SRC-1:0][3:0]  srcCode,
  input  logic [NUM_SRC-1:0][15:0] srcRid,
  input  logic [NUM_SRC-1:0][15:0] srcDom,
  input  logic [NUM_SRC-1:0][63:0] srcAddr,
  input  logic [IDX_W-1:0]        winIdx,
  input  ctlStrobe_t              strobe,
  input  logic                    regWrEn,
  input  logic [15:0]             regAddr,
  input  logic [63:0]             regWrData,
  output logic [63:0]             regRdData,
  output logic                    logEn,
  output logic                    logFull,
  output logic [63:0]             memWrAddr,
  output logic [127:0]            memWrData,
  output logic                    evtIrq
);

  logic [63:12]      baseHi;
  logic              ctlEn, ctlIrq;
  logic [EXP_W-1:0]  ctlExp;
  logic [SLOT_W-1:0] headSlot, tailSlot;
  logic              ovfFlag;
  logic [127:0]      entryReg;
  logic              irqReg;

  logic [EXP_W-1:0]  effExp;
  logic [SLOT_W-1:0] slotMask, tailNext;
  logic              wrBase, wrCtrl, wrHead, wrTail, wrStat;
  evRec_t            winRec;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData;

  // ring geometry
  always_comb begin
    if (ctlExp == '0)                    effExp = EXP_W'(1);
    else if (ctlExp > EXP_W'(MAX_EXP))   effExp = EXP_W'(MAX_EXP);
    else                                 effExp = ctlExp;
  end

  assign slotMask = ~({SLOT_W{1'b1}} << effExp);
  assign tailNext = (tailSlot + SLOT_W'(1)) & slotMask;
  assign logFull  = (tailNext == (headSlot & slotMask));
  assign logEn    = ctlEn;

  // register decode
  assign wrBase = regWrEn && (regAddr == OFS_BASE);
  assign wrCtrl = regWrEn && (regAddr == OFS_CTRL);
  assign wrHead = regWrEn && (regAddr == OFS_HEAD);
  assign wrTail = regWrEn && (regAddr == OFS_TAIL);
  assign wrStat = regWrEn && (regAddr == OFS_STAT);

  // record selection and formatting
  always_comb begin
    winRec.code = srcCode[winIdx];
    winRec.rid  = srcRid[winIdx];
    winRec.dom  = srcDom[winIdx];
    winRec.addr = srcAddr[winIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi   <= '0;
      ctlEn    <= 1'b0;
      ctlIrq   <= 1'b0;
      ctlExp   <= '0;
      headSlot <= '0;
      tailSlot <= '0;
      ovfFlag  <= 1'b0;
      entryReg <= '0;
      irqReg   <= 1'b0;
    end else begin
      irqReg <= strobe.advance && ctlIrq;
      if (strobe.capture) entryReg <= packEntry(winRec);
      if (strobe.advance) tailSlot <= tailNext;
      if (wrBase) baseHi <= regWrData[63:12];
      if (wrCtrl) begin
        ctlEn  <= regWrData[0];
        ctlIrq <= regWrData[1];
        ctlExp <= regWrData[8 +: EXP_W];
      end
      if (wrHead) headSlot <= regWrData[PTR_W-1:4];
      if (wrTail) tailSlot <= regWrData[PTR_W-1:4];
      if (wrStat && regWrData[0]) ovfFlag <= 1'b0;
      if (strobe.drop) ovfFlag <= 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      OFS_BASE: regRdData = {baseHi, 12'h0};
      OFS_CTRL: regRdData = 64'({ctlExp, 6'h0, ctlIrq, ctlEn});
      OFS_HEAD: regRdData = 64'({headSlot, 4'h0});
      OFS_TAIL: regRdData = 64'({tailSlot, 4'h0});
      OFS_STAT: regRdData = 64'(ovfFlag);
      default:  regRdData = '0;
    endcase
  end

  assign memWrAddr = {baseHi, 12'h0} + 64'({tailSlot, 4'h0});
  assign memWrData = entryReg;
  assign evtIrq    = irqReg;

  // R11: overflow flag clears only by software
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !wrStat) |=> ovfFlag);

  // R5: tail moves only on a completed write or a software write
  p_tail_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !wrTail) |=> $stable(tailSlot));

  // R9: a dropped event leaves tail in place
  p_drop_keeps_tail_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drop && !wrTail) |=> $stable(tailSlot));

endmodule

// File: rtl/evlog_ring_producer.sv
module evlog_ring_producer
  import evlog_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int MAX_EXP = 15,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       srcValid,
  input  logic [NUM_SRC-1:0][3:0]  srcCode,
  input  logic [NUM_SRC-1:0][15:0] srcRid,
  input  logic [NUM_SRC-1:0][15:0] srcDom,
  input  logic [NUM_SRC-1:0][63:0] srcAddr,
  output logic [NUM_SRC-1:0]       srcReady,
  input  logic                     regWrEn,
  input  logic [15:0]              regAddr,
  input  logic [63:0]              regWrData,
  output logic [63:0]              regRdData,
  output logic                     memWrValid,
  input  logic                     memWrReady,
  output logic [63:0]              memWrAddr,
  output logic [127:0]             memWrData,
  output logic                     evtIrq
);

  logic             logEn, logFull;
  logic [IDX_W-1:0] winIdx;
  ctlStrobe_t       strobe;

  evlog_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .srcValid   (srcValid),
    .logEn      (logEn),
    .logFull    (logFull),
    .memWrReady (memWrReady),
    .srcReady   (srcReady),
    .winIdx     (winIdx),
    .strobe     (strobe),
    .memWrValid (memWrValid)
  );

  evlog_dp #(.NUM_SRC(NUM_SRC), .MAX_EXP(MAX_EXP)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcCode   (srcCode),
    .srcRid    (srcRid),
    .srcDom    (srcDom),
    .srcAddr   (srcAddr),
    .winIdx    (winIdx),
    .strobe    (strobe),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .logEn     (logEn),
    .logFull   (logFull),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .evtIrq    (evtIrq)
  );

  // R8: interrupt only right after a completed write
  p_irq_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    evtIrq |-> $past(memWrValid && memWrReady));

  // R12: address and data stay put while stalled
  p_stall_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady && !regWrEn) |=>
      ($stable(memWrAddr) && $stable(memWrData)));

endmodule

// File: tb/tb_evlog_ring_producer.sv
module tb_evlog_ring_producer;

  localparam int NS = 4;
  localparam logic [63:0] BASE = 64'h0000_0012_3456_7000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NS-1:0]       srcValid = '0;
  logic [NS-1:0][3:0]  srcCode = '0;
  logic [NS-1:0][15:0] srcRid = '0;
  logic [NS-1:0][15:0] srcDom = '0;
  logic [NS-1:0][63:0] srcAddr = '0;
  logic [NS-1:0]       srcReady;
  logic                regWrEn = 1'b0;
  logic [15:0]         regAddr = '0;
  logic [63:0]         regWrData = '0;
  logic [63:0]         regRdData;
  logic                memWrValid;
  logic                memWrReady = 1'b1;
  logic [63:0]         memWrAddr;
  logic [127:0]        memWrData;
  logic                evtIrq;

  evlog_ring_producer #(.NUM_SRC(NS), .MAX_EXP(15)) dut (.*);

  always #4 clk = ~clk;

  int nChk = 0, nBad = 0, capCnt = 0, irqCnt = 0;
  logic [63:0]  capAddr [64];
  logic [127:0] capData [64];
  bit finished = 0;

  always @(posedge clk) begin
    if (rstN && memWrValid && memWrReady) begin
      capAddr[capCnt] <= memWrAddr;
      capData[capCnt] <= memWrData;
      capCnt <= capCnt + 1;
    end
    if (rstN && evtIrq) irqCnt <= irqCnt + 1;
  end

  // stimulus table: source, code, requester, domain, address, expected tail after write
  localparam int NV = 6;
  localparam logic [1:0]  V_SRC  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd0};
  localparam logic [3:0]  V_CODE [NV] = '{4'd1, 4'd2, 4'd3, 4'd8, 4'd5, 4'd7};
  localparam logic [15:0] V_RID  [NV] = '{16'h0100, 16'h02A8, 16'hFFFF, 16'h0000, 16'h1234, 16'h8001};
  localparam logic [15:0] V_DOM  [NV] = '{16'h0001, 16'h0002, 16'hABCD, 16'h7FFF, 16'h0000, 16'h5555};
  localparam logic [63:0] V_ADDR [NV] = '{64'h0000_0000_DEAD_B000, 64'hFFFF_FFFF_FFFF_FFFF,
                                         64'h0, 64'h8000_0000_0000_0001,
                                         64'h0000_7FFF_0012_3450, 64'h1111_2222_3333_4444};
  localparam logic [63:0] V_TAIL [NV] = '{64'h10, 64'h20, 64'h30, 64'h40, 64'h50, 64'h60};

  function automatic logic [127:0] expEntry(logic [3:0] c, logic [15:0] r,
                                             logic [15:0] d, logic [63:0] a);
    return {a, 16'h0, d, r, 12'h0, c};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pushEvt(int s, logic [3:0] c, logic [15:0] r, logic [15:0] d, logic [63:0] a);
    @(negedge clk);
    srcCode[s] = c; srcRid[s] = r; srcDom[s] = d; srcAddr[s] = a;
    srcValid[s] = 1'b1;
    #1;
    while (!srcReady[s]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 srcValid[s] = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nChk++; nBad++;
    $display("FAIL watchdog act=hung exp=done");
    finish();
  end

  initial begin
    logic [63:0] rd;
    int c0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    chk("R1 memWrValid", 128'(memWrValid), 128'd0);
    chk("R1 evtIrq", 128'(evtIrq), 128'd0);
    chk("R1 srcReady", 128'(srcReady), 128'd0);
    regRead(16'h2018, rd); chk("R1 tail", 128'(rd), 128'd0);
    regRead(16'h2010, rd); chk("R1 head", 128'(rd), 128'd0);
    regRead(16'h2020, rd); chk("R1 status", 128'(rd), 128'd0);
    regRead(16'h0018, rd); chk("R1 control", 128'(rd), 128'd0);

    // R2 register map
    regWrite(16'h0010, BASE | 64'hABC);
    regRead(16'h0010, rd); chk("R2 base low bits", 128'(rd), 128'(BASE));
    regWrite(16'h2010, 64'h2F);
    regRead(16'h2010, rd); chk("R2 head mask", 128'(rd), 128'h20);
    regRead(16'h0100, rd); chk("R2 unmapped", 128'(rd), 128'd0);
    regWrite(16'h0018, 64'h303);
    regRead(16'h0018, rd); chk("R2 control", 128'(rd), 128'h303);
    regWrite(16'h2010, 64'h0);

    // table walk: R3 address, R4 layout, R5 tail, with interrupt on
    for (int k = 0; k < NV; k++) begin
      c0 = capCnt;
      pushEvt(V_SRC[k], V_CODE[k], V_RID[k], V_DOM[k], V_ADDR[k]);
      repeat (3) @(negedge clk);
      chk("R3 one write", 128'(capCnt - c0), 128'd1);
      chk("R3 address", 128'(capAddr[c0]), 128'(BASE + 64'(16 * k)));
      chk("R4 entry", capData[c0], expEntry(V_CODE[k], V_RID[k], V_DOM[k], V_ADDR[k]));
      regRead(16'h2018, rd); chk("R5 tail", 128'(rd), 128'(V_TAIL[k]));
    end
    chk("R8 irq count", 128'(irqCnt), 128'(NV));

    // R8 interrupt disabled
    regWrite(16'h0018, 64'h301);
    pushEvt(3, 4'd6, 16'h0042, 16'h0007, 64'h5000);
    repeat (4) @(negedge clk);
    chk("R8 no irq when off", 128'(irqCnt), 128'(NV));

    // R6 priority
    regWrite(16'h2010, 64'h0);
    regWrite(16'h2018, 64'h0);
    c0 = capCnt;
    fork
      pushEvt(2, 4'd4, 16'h0202, 16'h0022, 64'h2000);
      pushEvt(0, 4'd2, 16'h0101, 16'h0011, 64'h1000);
    join
    repeat (4) @(negedge clk);
    chk("R6 first code", 128'(capData[c0][3:0]), 128'd2);
    chk("R6 second code", 128'(capData[c0+1][3:0]), 128'd4);

    // R7 disabled logging
    regWrite(16'h0018, 64'h300);
    c0 = capCnt;
    @(negedge clk);
    srcValid[1] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1 chk("R7 no ack", 128'(srcReady), 128'd0);
      @(negedge clk);
    end
    srcValid[1] = 1'b0;
    chk("R7 no write", 128'(capCnt - c0), 128'd0);

    // R9 full ring, R10 head frees slot, R11 sticky overflow
    regWrite(16'h0018, 64'h201);
    regWrite(16'h2010, 64'h0);
    regWrite(16'h2018, 64'h0);
    c0 = capCnt;
    for (int i = 0; i < 3; i++) pushEvt(1, 4'd2, 16'(i), 16'h0, 64'(i));
    repeat (3) @(negedge clk);
    chk("R9 fill writes", 128'(capCnt - c0), 128'd3);
    pushEvt(2, 4'd7, 16'h0099, 16'h0, 64'h99);
    repeat (3) @(negedge clk);
    chk("R9 dropped", 128'(capCnt - c0), 128'd3);
    regRead(16'h2018, rd); chk("R9 tail kept", 128'(rd), 128'h30);
    regRead(16'h2020, rd); chk("R9 overflow set", 128'(rd), 128'd1);
    regWrite(16'h2010, 64'h10);
    pushEvt(3, 4'd8, 16'h0077, 16'h0003, 64'h7700);
    repeat (3) @(negedge clk);
    chk("R10 write after head", 128'(capCnt - c0), 128'd4);
    chk("R10 slot address", 128'(capAddr[c0+3]), 128'(BASE + 64'h30));
    regRead(16'h2018, rd); chk("R5 wrap", 128'(rd), 128'd0);
    regRead(16'h2020, rd); chk("R11 still set", 128'(rd), 128'd1);
    regWrite(16'h2020, 64'h1);
    regRead(16'h2020, rd); chk("R11 cleared", 128'(rd), 128'd0);

    // R12 back-pressure
    regWrite(16'h2010, 64'h0);
    memWrReady = 1'b0;
    c0 = capCnt;
    pushEvt(0, 4'd5, 16'h0505, 16'h0505, 64'h5050);
    repeat (5) @(negedge clk);
    #1;
    chk("R12 valid held", 128'(memWrValid), 128'd1);
    chk("R12 address", 128'(memWrAddr), 128'(BASE));
    chk("R12 data", memWrData, expEntry(4'd5, 16'h0505, 16'h0505, 64'h5050));
    chk("R12 no write", 128'(capCnt - c0), 128'd0);
    regRead(16'h2018, rd); chk("R12 tail kept", 128'(rd), 128'd0);
    memWrReady = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 released", 128'(capCnt - c0), 128'd1);
    regRead(16'h2018, rd); chk("R12 tail moved", 128'(rd), 128'h10);

    finish();
  end

endmodule